// File: doc/BRIEF.md
# Priority Port Pin Function Multiplexer

This block arbitrates eight bidirectional pins among four possible users: the upper data byte of an external memory bus, an LPC host link, an 8-bit parallel host data bus, and a plain general-purpose I/O port. On every clock edge it registers which function owns the pins. The choice comes from the operating mode, an expansion enable, three LPC channel enables and a parallel-host enable. The owner alone supplies each pin's output value and output enable. The pin levels are routed back to the owner only.

The I/O port side holds two CPU-visible registers: an output data register and a direction register. A read of the data address mixes the two sources bit by bit. Output pins return the register bit. Input pins return the pin level after it passes through a two-stage synchronizer. While a peripheral owns the pins, the CPU can still write and read both registers, but they do not reach the pins.

Top module: `pin_func_mux`

## Requirements
- R1: When mode is 2 or 3 (mode[1]=1) and exp_en is 1, the external bus owns the pins: pin_oe=ext_oe, pin_out=ext_out and ext_in=pin_in, whatever lpc_en and phb_en hold.
- R2: When mode is 1, the external bus owns the pins whatever exp_en, lpc_en and phb_en hold.
- R3: When neither R1 nor R2 applies and any bit of lpc_en is 1, the LPC side owns the pins (pin_oe=lpc_oe, pin_out=lpc_out, lpc_in=pin_in), even if phb_en is 1.
- R4: When neither R1 nor R2 applies, lpc_en is 0 and phb_en is 1, the parallel host side owns the pins (pin_oe=phb_oe, pin_out=phb_out, phb_in=pin_in).
- R5: When none of the above applies, the I/O port owns the pins: pin_oe equals the direction register, and pin_out equals the data register on bits whose direction bit is 1 and is 0 on the other bits.
- R6: After reset, the data and direction registers are 8'h00, the I/O port owns the pins and every pin_oe bit is 0.
- R7: A write with cpu_addr=1 loads the direction register, and a write with cpu_addr=0 loads the data register, both at the clock edge. A read with cpu_addr=1 returns the direction register.
- R8: A read with cpu_addr=0 returns the data register bit for pins whose direction bit is 1. For pins whose direction bit is 0 it returns the pin level sampled two clock edges earlier.
- R9: While a peripheral owns the pins, register writes still update the registers and stay readable, but they leave pin_oe and pin_out unchanged.
- R10: A change of the enable or mode inputs changes the owner only at the next rising clock edge. Until that edge the pins keep following the previous owner, and exactly one owner is selected at any time.
- R11: The input buses ext_in, lpc_in and phb_in of every function that does not own the pins read 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Operating mode number |
| exp_en | input | 1 | Expansion enable for modes 2 and 3 |
| lpc_en | input | 3 | LPC channel enables |
| phb_en | input | 1 | Parallel host bus enable |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 1 | Register select: 0 data, 1 direction |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| ext_oe | input | 8 | External bus per-pin output enables |
| ext_out | input | 8 | External bus per-pin output values |
| ext_in | output | 8 | Pin levels routed to the external bus |
| lpc_oe | input | 8 | LPC per-pin output enables |
| lpc_out | input | 8 | LPC per-pin output values |
| lpc_in | output | 8 | Pin levels routed to the LPC side |
| phb_oe | input | 8 | Parallel host per-pin output enables |
| phb_out | input | 8 | Parallel host per-pin output values |
| phb_in | output | 8 | Pin levels routed to the parallel host side |
| pin_in | input | 8 | Pad input levels |
| pin_oe | output | 8 | Pad output enables |
| pin_out | output | 8 | Pad output values |

## Verification
Each function drives its own output pattern and enable pattern (ext 8'hA5/8'hF0, LPC 8'h3C/8'h0F, parallel host 8'h96/8'hFF), so any wrong owner shows up on the pins at once. The enable inputs are walked through every LPC channel alone with the parallel host enable also set, and through modes 1, 2 and 3 with and without expansion. This separates priority mistakes from decode mistakes. Pin input values change between steps, so stale routing and a missing or extra synchronizer stage give different read values. Register writes made while a peripheral owns the port show whether the registers leak onto the pins.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    // One-hot pin owner; exactly one bit set at all times
    typedef enum logic [3:0] {
        OWN_GPIO = 4'b0001,
        OWN_PHB  = 4'b0010,
        OWN_LPC  = 4'b0100,
        OWN_EXT  = 4'b1000
    } owner_e;

    localparam logic [1:0] MODE_EXT_ONLY = 2'd1;

endpackage

// File: rtl/ppm_owner_sel.sv
module ppm_owner_sel
    import ppm_pkg::*;
#(
    parameter int LPC_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              exp_en,
    input  logic [LPC_CH-1:0] lpc_en,
    input  logic              phb_en,
    output owner_e            owner_q
);

    typedef struct packed {
        owner_e owner;
    } sel_t;

    sel_t sel_d, sel_q;
    logic ext_req;
    logic lpc_req;

    always_comb begin
        ext_req = (mode == MODE_EXT_ONLY) || (mode[1] && exp_en);
        lpc_req = |lpc_en;
        sel_d   = sel_q;
        if (ext_req) begin
            sel_d.owner = OWN_EXT;
        end else if (lpc_req) begin
            sel_d.owner = OWN_LPC;
        end else if (phb_en) begin
            sel_d.owner = OWN_PHB;
        end else begin
            sel_d.owner = OWN_GPIO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q.owner <= OWN_GPIO;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign owner_q = sel_q.owner;

    AST_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(owner_q)); // R10
    AST_MODE1_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |=> (owner_q == OWN_EXT)); // R2
    AST_EXPANSION_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && exp_en) |=> (owner_q == OWN_EXT)); // R1
    AST_LPC_OVER_PHB: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_req && (lpc_en != '0)) |=> (owner_q == OWN_LPC)); // R3
    AST_PHB_OVER_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_req && (lpc_en == '0) && phb_en) |=> (owner_q == OWN_PHB)); // R4

endmodule

// File: rtl/ppm_gpio_regs.sv
module ppm_gpio_regs #(
    parameter int PIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic             cpu_addr,
    input  logic [PIN_W-1:0] cpu_wdata,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] dr_q,
    output logic [PIN_W-1:0] ddr_q,
    output logic [PIN_W-1:0] cpu_rdata
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [PIN_W-1:0]                   dr;
        logic [PIN_W-1:0]                   ddr;
        logic [SYNC_STAGES-1:0][PIN_W-1:0]  sync;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cpu_wr) begin
            if (cpu_addr) begin
                r_d.ddr = cpu_wdata;
            end else begin
                r_d.dr = cpu_wdata;
            end
        end
        r_d.sync[0] = pin_in;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            r_d.sync[s] = r_q.sync[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dr_q  = r_q.dr;
    assign ddr_q = r_q.ddr;

    always_comb begin
        if (cpu_addr) begin
            cpu_rdata = r_q.ddr;
        end else begin
            cpu_rdata = (r_q.dr & r_q.ddr) | (r_q.sync[LAST] & ~r_q.ddr);
        end
    end

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr) |=> (ddr_q == $past(cpu_wdata))); // R7
    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_addr) |=> (dr_q == $past(cpu_wdata))); // R7
    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> ($stable(dr_q) && $stable(ddr_q))); // R9

endmodule

// File: rtl/ppm_pin_drive.sv
module ppm_pin_drive
    import ppm_pkg::*;
#(
    parameter int PIN_W = 8
) (
    input  owner_e           owner,
    input  logic [PIN_W-1:0] dr,
    input  logic [PIN_W-1:0] ddr,
    input  logic [PIN_W-1:0] ext_oe,
    input  logic [PIN_W-1:0] ext_out,
    input  logic [PIN_W-1:0] lpc_oe,
    input  logic [PIN_W-1:0] lpc_out,
    input  logic [PIN_W-1:0] phb_oe,
    input  logic [PIN_W-1:0] phb_out,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_oe,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] ext_in,
    output logic [PIN_W-1:0] lpc_in,
    output logic [PIN_W-1:0] phb_in
);

    for (genvar p = 0; p < PIN_W; p++) begin : g_pin
        always_comb begin
            unique case (owner)
                OWN_EXT: begin
                    pin_oe[p]  = ext_oe[p];
                    pin_out[p] = ext_out[p];
                end
                OWN_LPC: begin
                    pin_oe[p]  = lpc_oe[p];
                    pin_out[p] = lpc_out[p];
                end
                OWN_PHB: begin
                    pin_oe[p]  = phb_oe[p];
                    pin_out[p] = phb_out[p];
                end
                default: begin
                    pin_oe[p]  = ddr[p];
                    pin_out[p] = dr[p] & ddr[p];
                end
            endcase
        end

        assign ext_in[p] = pin_in[p] & (owner == OWN_EXT);
        assign lpc_in[p] = pin_in[p] & (owner == OWN_LPC);
        assign phb_in[p] = pin_in[p] & (owner == OWN_PHB);
    end

endmodule

// File: rtl/pin_func_mux.sv
module pin_func_mux
    import ppm_pkg::*;
#(
    parameter int PIN_W       = 8,
    parameter int LPC_CH      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              exp_en,
    input  logic [LPC_CH-1:0] lpc_en,
    input  logic              phb_en,
    input  logic              cpu_wr,
    input  logic              cpu_addr,
    input  logic [PIN_W-1:0]  cpu_wdata,
    output logic [PIN_W-1:0]  cpu_rdata,
    input  logic [PIN_W-1:0]  ext_oe,
    input  logic [PIN_W-1:0]  ext_out,
    output logic [PIN_W-1:0]  ext_in,
    input  logic [PIN_W-1:0]  lpc_oe,
    input  logic [PIN_W-1:0]  lpc_out,
    output logic [PIN_W-1:0]  lpc_in,
    input  logic [PIN_W-1:0]  phb_oe,
    input  logic [PIN_W-1:0]  phb_out,
    output logic [PIN_W-1:0]  phb_in,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_oe,
    output logic [PIN_W-1:0]  pin_out
);

    owner_e           owner_q;
    logic [PIN_W-1:0] dr_q;
    logic [PIN_W-1:0] ddr_q;

    ppm_owner_sel #(
        .LPC_CH (LPC_CH)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .exp_en  (exp_en),
        .lpc_en  (lpc_en),
        .phb_en  (phb_en),
        .owner_q (owner_q)
    );

    ppm_gpio_regs #(
        .PIN_W       (PIN_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .pin_in    (pin_in),
        .dr_q      (dr_q),
        .ddr_q     (ddr_q),
        .cpu_rdata (cpu_rdata)
    );

    ppm_pin_drive #(
        .PIN_W (PIN_W)
    ) u_drive (
        .owner   (owner_q),
        .dr      (dr_q),
        .ddr     (ddr_q),
        .ext_oe  (ext_oe),
        .ext_out (ext_out),
        .lpc_oe  (lpc_oe),
        .lpc_out (lpc_out),
        .phb_oe  (phb_oe),
        .phb_out (phb_out),
        .pin_in  (pin_in),
        .pin_oe  (pin_oe),
        .pin_out (pin_out),
        .ext_in  (ext_in),
        .lpc_in  (lpc_in),
        .phb_in  (phb_in)
    );

    AST_GPIO_DIR_ON_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_GPIO) |-> (pin_oe == ddr_q)); // R5
    AST_PERIPH_PINS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((owner_q == OWN_PHB) && $stable(owner_q) && $stable(phb_oe) && $stable(phb_out))
        |-> ($stable(pin_oe) && $stable(pin_out))); // R9
    AST_IDLE_INPUTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_GPIO) |-> ((ext_in | lpc_in | phb_in) == '0)); // R11

endmodule

// File: tb/pin_func_mux_tb.sv
module pin_func_mux_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd2;
    logic       exp_en = 1'b0;
    logic [2:0] lpc_en = 3'b000;
    logic       phb_en = 1'b0;
    logic       cpu_wr = 1'b0;
    logic       cpu_addr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic [7:0] ext_oe = 8'hF0, ext_out = 8'hA5, ext_in;
    logic [7:0] lpc_oe = 8'h0F, lpc_out = 8'h3C, lpc_in;
    logic [7:0] phb_oe = 8'hFF, phb_out = 8'h96, phb_in;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_oe, pin_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_func_mux u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .exp_en(exp_en),
        .lpc_en(lpc_en), .phb_en(phb_en), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ext_oe(ext_oe), .ext_out(ext_out), .ext_in(ext_in),
        .lpc_oe(lpc_oe), .lpc_out(lpc_out), .lpc_in(lpc_in),
        .phb_oe(phb_oe), .phb_out(phb_out), .phb_in(phb_in),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    int n_run = 0;
    int n_fail = 0;

    // Bench model state (0 gpio, 1 phb, 2 lpc, 3 ext)
    int         m_own = 0;
    logic [7:0] m_dr = 8'h00, m_ddr = 8'h00, m_s1 = 8'h00, m_s2 = 8'h00;

    typedef struct {
        logic [7:0] oe, out, rd, e_in, l_in, p_in;
    } exp_t;
    exp_t  sbq[$];
    string tagq[$];

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int own_of(input logic [1:0] md, input logic ex,
                                  input logic [2:0] le, input logic pe);
        if (md == 2'd1 || (md[1] && ex)) return 3;
        if (le != 3'b000) return 2;
        if (pe) return 1;
        return 0;
    endfunction

    function automatic exp_t predict(input int own, input logic [7:0] pin,
                                     input logic ad);
        exp_t e;
        e.e_in = 8'h00; e.l_in = 8'h00; e.p_in = 8'h00;
        case (own)
            3: begin e.oe = ext_oe; e.out = ext_out; e.e_in = pin; end
            2: begin e.oe = lpc_oe; e.out = lpc_out; e.l_in = pin; end
            1: begin e.oe = phb_oe; e.out = phb_out; e.p_in = pin; end
            default: begin e.oe = m_ddr; e.out = m_dr & m_ddr; end
        endcase
        e.rd = ad ? m_ddr : ((m_dr & m_ddr) | (m_s2 & ~m_ddr));
        return e;
    endfunction

    // Driver: apply inputs, confirm old owner holds until the edge, push expectation
    task automatic step(input logic [1:0] md, input logic ex, input logic [2:0] le,
                        input logic pe, input logic wr, input logic ad,
                        input logic [7:0] wd, input logic [7:0] pin, input string tag);
        exp_t pre;
        @(negedge clk); #2;
        mode = md; exp_en = ex; lpc_en = le; phb_en = pe;
        cpu_wr = wr; cpu_addr = ad; cpu_wdata = wd; pin_in = pin;
        #1;
        pre = predict(m_own, pin, ad);
        chk({tag, " / R10 before edge"}, "pin_oe", pin_oe, pre.oe);
        chk({tag, " / R10 before edge"}, "pin_out", pin_out, pre.out);
        @(posedge clk);
        if (wr) begin
            if (ad) m_ddr = wd; else m_dr = wd;
        end
        m_s2 = m_s1;
        m_s1 = pin;
        m_own = own_of(md, ex, le, pe);
        sbq.push_back(predict(m_own, pin, ad));
        tagq.push_back(tag);
    endtask

    // Monitor: compare one queued expectation per falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                exp_t  e;
                string t;
                e = sbq.pop_front();
                t = tagq.pop_front();
                chk(t, "pin_oe", pin_oe, e.oe);
                chk(t, "pin_out", pin_out, e.out);
                chk(t, "cpu_rdata", cpu_rdata, e.rd);
                chk({t, " / R11"}, "ext_in", ext_in, e.e_in);
                chk({t, " / R11"}, "lpc_in", lpc_in, e.l_in);
                chk({t, " / R11"}, "phb_in", phb_in, e.p_in);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R6: reset state
        chk("R6 reset", "pin_oe", pin_oe, 8'h00);
        chk("R6 reset", "cpu_rdata data", cpu_rdata, 8'h00);
        cpu_addr = 1'b1;
        #1;
        chk("R6 reset", "cpu_rdata dir", cpu_rdata, 8'h00);

        step(2'd2, 1'b0, 3'b000, 1'b0, 1'b1, 1'b1, 8'h0F, 8'h00, "R7 dir write");
        step(2'd2, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 8'h5A, 8'h00, "R5 gpio drive");
        step(2'd2, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC3, "R8 sync first edge");
        step(2'd2, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 8'hC3, "R8 sync second edge");
        step(2'd2, 1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 8'h00, 8'hC3, "R7 dir read");
        step(2'd2, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 8'h00, 8'h77, "R4 phb owns");
        step(2'd2, 1'b0, 3'b000, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h77, "R9 data write under phb");
        step(2'd2, 1'b0, 3'b000, 1'b1, 1'b1, 1'b1, 8'hF0, 8'h77, "R9 dir write under phb");
        step(2'd2, 1'b0, 3'b000, 1'b1, 1'b0, 1'b1, 8'h00, 8'h77, "R9 dir readable");
        step(2'd2, 1'b0, 3'b000, 1'b1, 1'b1, 1'b1, 8'h0F, 8'h77, "R9 dir restore");
        step(2'd2, 1'b0, 3'b001, 1'b1, 1'b0, 1'b0, 8'h00, 8'h81, "R3 lpc ch0 over phb");
        step(2'd2, 1'b0, 3'b010, 1'b1, 1'b0, 1'b0, 8'h00, 8'h42, "R3 lpc ch1 over phb");
        step(2'd3, 1'b0, 3'b100, 1'b1, 1'b0, 1'b0, 8'h00, 8'h24, "R3 lpc ch2 mode3");
        step(2'd2, 1'b1, 3'b111, 1'b1, 1'b0, 1'b0, 8'h00, 8'h18, "R1 ext mode2");
        step(2'd3, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 8'hE7, "R1 ext mode3");
        step(2'd1, 1'b0, 3'b111, 1'b1, 1'b0, 1'b0, 8'h00, 8'h5A, "R2 mode1 no exp");
        step(2'd1, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA5, "R2 mode1 with exp");
        step(2'd0, 1'b1, 3'b000, 1'b1, 1'b0, 1'b0, 8'h00, 8'h3C, "R4 mode0 phb");
        step(2'd2, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C, "R5 back to gpio");
        step(2'd2, 1'b0, 3'b000, 1'b0, 1'b1, 1'b1, 8'hF0, 8'h3C, "R5 dir flip");
        step(2'd2, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C, "R8 input half read");
        step(2'd2, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C, "R8 input half settled");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule